// File: doc/BRIEF.md
# Per-Core Write Queue with Load Forwarding

This block sits between one core's load/store port and a shared memory port. Stores from the core are taken into a small circular queue in program order. The core does not wait for them to reach memory. Entries leave the queue one at a time, oldest first. An entry may be written to shared memory only after an external arbiter grants ownership of the location, so a queued store stays invisible to every other agent until the cycle it is written.

Loads are answered in the same cycle they are presented. The newest matching value the core itself has produced wins. The order of precedence is:

1. a store accepted in that same cycle;
2. otherwise the youngest queued entry with the same address;
3. otherwise the word that shared memory returns for the load address.

A queued store is never dropped because another agent wrote the same location first. It still drains later and overwrites that value.

The store port uses valid/ready. A store transfers on a cycle where both `st_valid` and `st_ready` are high. `st_ready` is low exactly while the queue holds `DEPTH` entries. While it is low, the core must hold the store's address and data. The drain side is a plain request/grant pair: `drain_req` is high whenever the queue is not empty, and the head entry is written on a cycle where `drain_gnt` is also high.

Top module: `store_queue_fwd`

## Requirements
- R1: While fewer than DEPTH entries are held, `st_ready` is high and a valid store is accepted on that edge, whether or not any grant has arrived.
- R2: With DEPTH entries held, `sq_full` is high and `st_ready` is low; a store presented then is not taken, and no later drain or load shows its address or data.
- R3: A load whose address equals a queued entry's address returns that entry's data with `ld_hit` high, even after another agent has written a different value to that address in memory.
- R4: When several queued entries share the load address, the most recently enqueued one supplies `ld_data`.
- R5: A store accepted in the same cycle as a load to the same address supplies that load's data, taking precedence over older queued entries.
- R6: A load matching no queued entry and no same-cycle store returns `mem_rd_data` with `ld_hit` low.
- R7: `mem_wr_en` stays low while entries merely wait in the queue; no queued value reaches memory before its drain cycle.
- R8: `drain_req` is high whenever the queue is non-empty, and the head is written (`mem_wr_en` high) only on a cycle with `drain_gnt` high.
- R9: Entries are written to memory in the order they were accepted, one per granted cycle, with `mem_wr_addr`/`mem_wr_data` equal to the oldest entry.
- R10: A queued store whose address was written by another agent earlier still drains, so memory ends holding the value of whichever write drained last.
- R11: After reset the queue is empty: `sq_empty` high, `sq_full` low, `st_ready` high, `drain_req` low, `ld_hit` low.
- R12: Once a store has drained and no newer local entry matches, loads of that address come from memory (`ld_hit` low) and return the drained value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store request valid |
| st_ready | output | 1 | Queue can accept a store |
| st_addr | input | ADDR_W | Store word address |
| st_data | input | DATA_W | Store data |
| ld_valid | input | 1 | Load lookup enable |
| ld_addr | input | ADDR_W | Load word address |
| ld_data | output | DATA_W | Load result (forwarded or memory) |
| ld_hit | output | 1 | Load result came from this core's own stores |
| mem_rd_addr | output | ADDR_W | Shared memory read address (follows `ld_addr`) |
| mem_rd_data | input | DATA_W | Shared memory read data, same cycle |
| drain_req | output | 1 | Head entry wants ownership to drain |
| drain_addr | output | ADDR_W | Address of the head entry |
| drain_gnt | input | 1 | Ownership granted for the head entry this cycle |
| mem_wr_en | output | 1 | Shared memory write strobe |
| mem_wr_addr | output | ADDR_W | Shared memory write address |
| mem_wr_data | output | DATA_W | Shared memory write data |
| sq_full | output | 1 | Queue holds DEPTH entries |
| sq_empty | output | 1 | Queue holds no entries |

## Verification
The hardest situation to reach is two cores holding pending stores to one address, where they must disagree about its value until both have drained.

The bench builds two instances over a single bench memory and acts as the arbiter itself. Both cores store to the same word while grants are held off. The bench then grants the second core first, checks that the first core still sees its own pending value, and finally grants the first core so that its late write becomes the value both cores read.

Back-to-back stores into a full queue, and a store meeting a load in the same cycle, are produced by holding inputs across chosen negative edges.

// File: rtl/sq_pkg.sv
package sq_pkg;
  // Origin of the value returned to a load.
  typedef enum logic [1:0] {
    SRC_MEM    = 2'd0,
    SRC_QUEUE  = 2'd1,
    SRC_BYPASS = 2'd2
  } ld_src_e;
endpackage

// File: rtl/sq_ctrl.sv
module sq_ctrl #(
  parameter int DEPTH = 4,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = PW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  output logic [PW-1:0] head,
  output logic [PW-1:0] tail,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (push) tail <= tail + PW'(1);
      if (pop)  head <= head + PW'(1);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  assert_no_push_when_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push);
  assert_push_grows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> (count == $past(count) + CW'(1)));
  assert_pop_shrinks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> (count == $past(count) - CW'(1)));
endmodule

// File: rtl/sq_storage.sv
module sq_storage #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [PW-1:0]                 wr_idx,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [DATA_W-1:0]             wr_data,
  output logic [DEPTH-1:0][ADDR_W-1:0]  ent_addr,
  output logic [DEPTH-1:0][DATA_W-1:0]  ent_data
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_addr[i] <= '0;
        ent_data[i] <= '0;
      end else if (wr_en && (wr_idx == PW'(i))) begin
        ent_addr[i] <= wr_addr;
        ent_data[i] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/sq_match.sv
module sq_match #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = PW + 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [DEPTH-1:0][ADDR_W-1:0]  ent_addr,
  input  logic [DEPTH-1:0][DATA_W-1:0]  ent_data,
  input  logic [PW-1:0]                 head,
  input  logic [CW-1:0]                 count,
  input  logic                          ld_valid,
  input  logic [ADDR_W-1:0]             ld_addr,
  input  logic                          byp_valid,
  input  logic [ADDR_W-1:0]             byp_addr,
  input  logic [DATA_W-1:0]             byp_data,
  output logic [DATA_W-1:0]             fwd_data,
  output sq_pkg::ld_src_e               src
);
  logic [DEPTH-1:0]          age_hit;
  logic [DEPTH-1:0][PW-1:0]  age_idx;
  logic [DEPTH-1:0]          young_sel;
  logic [DATA_W-1:0]         q_data;

  // Age slot k is the k-th oldest live entry.
  for (genvar k = 0; k < DEPTH; k++) begin : g_age
    assign age_idx[k] = head + PW'(k);
    assign age_hit[k] = (CW'(k) < count) && (ent_addr[age_idx[k]] == ld_addr);
  end

  // Keep only the youngest matching slot.
  always_comb begin
    logic found;
    found     = 1'b0;
    young_sel = '0;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      if (age_hit[k] && !found) begin
        young_sel[k] = 1'b1;
        found        = 1'b1;
      end
    end
  end

  always_comb begin
    q_data = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (young_sel[k]) q_data = ent_data[age_idx[k]];
    end
  end

  always_comb begin
    src      = sq_pkg::SRC_MEM;
    fwd_data = q_data;
    if (ld_valid && byp_valid && (byp_addr == ld_addr)) begin
      src      = sq_pkg::SRC_BYPASS;
      fwd_data = byp_data;
    end else if (ld_valid && (|young_sel)) begin
      src = sq_pkg::SRC_QUEUE;
    end
  end

  assert_single_youngest_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(young_sel));
  assert_sel_is_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|young_sel) |-> (|age_hit));
endmodule

// File: rtl/store_queue_fwd.sv
module store_queue_fwd #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = PW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_valid,
  output logic              st_ready,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [DATA_W-1:0] st_data,
  input  logic              ld_valid,
  input  logic [ADDR_W-1:0] ld_addr,
  output logic [DATA_W-1:0] ld_data,
  output logic              ld_hit,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              drain_req,
  output logic [ADDR_W-1:0] drain_addr,
  input  logic              drain_gnt,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [DATA_W-1:0] mem_wr_data,
  output logic              sq_full,
  output logic              sq_empty
);
  logic                         push, pop;
  logic [PW-1:0]                head, tail;
  logic [CW-1:0]                count;
  logic [DEPTH-1:0][ADDR_W-1:0] ent_addr;
  logic [DEPTH-1:0][DATA_W-1:0] ent_data;
  logic [DATA_W-1:0]            fwd_data;
  sq_pkg::ld_src_e              src;

  assign st_ready = !sq_full;
  assign push     = st_valid && st_ready;
  assign drain_req = !sq_empty;
  assign pop      = drain_req && drain_gnt;

  sq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
    .head(head), .tail(tail), .count(count),
    .full(sq_full), .empty(sq_empty)
  );

  sq_storage #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(push), .wr_idx(tail),
    .wr_addr(st_addr), .wr_data(st_data),
    .ent_addr(ent_addr), .ent_data(ent_data)
  );

  sq_match #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_match (
    .clk(clk), .rst_n(rst_n),
    .ent_addr(ent_addr), .ent_data(ent_data), .head(head), .count(count),
    .ld_valid(ld_valid), .ld_addr(ld_addr),
    .byp_valid(push), .byp_addr(st_addr), .byp_data(st_data),
    .fwd_data(fwd_data), .src(src)
  );

  assign mem_rd_addr = ld_addr;
  assign ld_hit      = (src != sq_pkg::SRC_MEM);
  assign ld_data     = ld_hit ? fwd_data : mem_rd_data;

  assign drain_addr  = ent_addr[head];
  assign mem_wr_en   = pop;
  assign mem_wr_addr = ent_addr[head];
  assign mem_wr_data = ent_data[head];

  assert_wr_needs_gnt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> drain_gnt);
  assert_head_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_req && !drain_gnt) |=> (drain_req && (drain_addr == $past(drain_addr))));
  assert_no_write_when_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sq_empty |-> !mem_wr_en);
  assert_empty_not_full_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(sq_empty && sq_full));
endmodule

// File: tb/store_queue_fwd_bench.sv
module store_queue_fwd_bench;
  localparam int DEPTH = 4, AW = 8, DW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          c0_st_valid = 0, c1_st_valid = 0;
  logic [AW-1:0] c0_st_addr = 0, c1_st_addr = 0;
  logic [DW-1:0] c0_st_data = 0, c1_st_data = 0;
  logic          c0_ld_valid = 0, c1_ld_valid = 0;
  logic [AW-1:0] c0_ld_addr = 0, c1_ld_addr = 0;
  logic          c0_gnt = 0, c1_gnt = 0;
  logic          c0_st_ready, c1_st_ready, c0_ld_hit, c1_ld_hit;
  logic [DW-1:0] c0_ld_data, c1_ld_data, c0_rd_data, c1_rd_data;
  logic [AW-1:0] c0_rd_addr, c1_rd_addr, c0_daddr, c1_daddr;
  logic          c0_req, c1_req, c0_wen, c1_wen;
  logic [AW-1:0] c0_waddr, c1_waddr;
  logic [DW-1:0] c0_wdata, c1_wdata;
  logic          c0_full, c1_full, c0_empty, c1_empty;

  logic [DW-1:0] mem [0:(1<<AW)-1];
  assign c0_rd_data = mem[c0_rd_addr];
  assign c1_rd_data = mem[c1_rd_addr];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < (1 << AW); i++) mem[i] <= '0;
    end else begin
      if (c0_wen) mem[c0_waddr] <= c0_wdata;
      if (c1_wen) mem[c1_waddr] <= c1_wdata;
    end
  end

  store_queue_fwd #(.DEPTH(DEPTH), .ADDR_W(AW), .DATA_W(DW)) u_store_queue_fwd (
    .clk(clk), .rst_n(rst_n), .st_valid(c0_st_valid), .st_ready(c0_st_ready),
    .st_addr(c0_st_addr), .st_data(c0_st_data), .ld_valid(c0_ld_valid),
    .ld_addr(c0_ld_addr), .ld_data(c0_ld_data), .ld_hit(c0_ld_hit),
    .mem_rd_addr(c0_rd_addr), .mem_rd_data(c0_rd_data), .drain_req(c0_req),
    .drain_addr(c0_daddr), .drain_gnt(c0_gnt), .mem_wr_en(c0_wen),
    .mem_wr_addr(c0_waddr), .mem_wr_data(c0_wdata), .sq_full(c0_full),
    .sq_empty(c0_empty)
  );

  store_queue_fwd #(.DEPTH(DEPTH), .ADDR_W(AW), .DATA_W(DW)) u_store_queue_fwd_b (
    .clk(clk), .rst_n(rst_n), .st_valid(c1_st_valid), .st_ready(c1_st_ready),
    .st_addr(c1_st_addr), .st_data(c1_st_data), .ld_valid(c1_ld_valid),
    .ld_addr(c1_ld_addr), .ld_data(c1_ld_data), .ld_hit(c1_ld_hit),
    .mem_rd_addr(c1_rd_addr), .mem_rd_data(c1_rd_data), .drain_req(c1_req),
    .drain_addr(c1_daddr), .drain_gnt(c1_gnt), .mem_wr_en(c1_wen),
    .mem_wr_addr(c1_waddr), .mem_wr_data(c1_wdata), .sq_full(c1_full),
    .sq_empty(c1_empty)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // One store, accepted at the edge after the driving negedge.
  task automatic store(input int c, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    if (c == 0) begin c0_st_valid = 1; c0_st_addr = a; c0_st_data = d; end
    else        begin c1_st_valid = 1; c1_st_addr = a; c1_st_data = d; end
    #1;
    chk("R1", "st_ready on store", (c == 0) ? c0_st_ready : c1_st_ready, 1);
    @(negedge clk);
    if (c == 0) c0_st_valid = 0; else c1_st_valid = 0;
  endtask

  task automatic load(input int c, input logic [AW-1:0] a, input string req,
                      input logic [DW-1:0] ed, input logic eh);
    @(negedge clk);
    if (c == 0) begin c0_ld_valid = 1; c0_ld_addr = a; end
    else        begin c1_ld_valid = 1; c1_ld_addr = a; end
    #1;
    chk(req, "ld_data", (c == 0) ? c0_ld_data : c1_ld_data, ed);
    chk(req, "ld_hit",  (c == 0) ? c0_ld_hit  : c1_ld_hit,  eh);
    if (c == 0) c0_ld_valid = 0; else c1_ld_valid = 0;
  endtask

  task automatic drain(input int c, input logic [AW-1:0] ea, input logic [DW-1:0] ed);
    @(negedge clk);
    if (c == 0) c0_gnt = 1; else c1_gnt = 1;
    #1;
    chk("R9", "mem_wr_en",   (c == 0) ? c0_wen   : c1_wen,   1);
    chk("R9", "mem_wr_addr", (c == 0) ? c0_waddr : c1_waddr, ea);
    chk("R9", "mem_wr_data", (c == 0) ? c0_wdata : c1_wdata, ed);
    @(negedge clk);
    if (c == 0) c0_gnt = 0; else c1_gnt = 0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R11", "sq_empty",  c0_empty, 1);
    chk("R11", "sq_full",   c0_full, 0);
    chk("R11", "st_ready",  c0_st_ready, 1);
    chk("R11", "drain_req", c0_req, 0);
    chk("R11", "ld_hit",    c0_ld_hit, 0);
  endtask

  task automatic t_race;
    store(0, 8'h20, 16'h0001);
    store(1, 8'h20, 16'h0002);
    load(0, 8'h20, "R3", 16'h0001, 1);
    load(1, 8'h20, "R3", 16'h0002, 1);
    chk("R7", "memory untouched by queued stores", mem[8'h20], 16'h0000);
    drain(1, 8'h20, 16'h0002);
    chk("R10", "memory after first drain", mem[8'h20], 16'h0002);
    load(0, 8'h20, "R3", 16'h0001, 1);
    load(1, 8'h20, "R12", 16'h0002, 0);
    drain(0, 8'h20, 16'h0001);
    chk("R10", "late drain overwrites", mem[8'h20], 16'h0001);
    load(1, 8'h20, "R10", 16'h0001, 0);
    load(0, 8'h20, "R12", 16'h0001, 0);
  endtask

  task automatic t_youngest;
    store(0, 8'h40, 16'h0005);
    store(0, 8'h40, 16'h0006);
    store(0, 8'h41, 16'h0007);
    load(0, 8'h40, "R4", 16'h0006, 1);
    load(0, 8'h41, "R3", 16'h0007, 1);
    load(0, 8'h42, "R6", 16'h0000, 0);
    drain(0, 8'h40, 16'h0005);
    load(0, 8'h40, "R4", 16'h0006, 1);
    drain(0, 8'h40, 16'h0006);
    drain(0, 8'h41, 16'h0007);
    load(0, 8'h40, "R12", 16'h0006, 0);
  endtask

  task automatic t_bypass;
    store(0, 8'h50, 16'h0008);
    @(negedge clk);
    c0_st_valid = 1; c0_st_addr = 8'h50; c0_st_data = 16'h0009;
    c0_ld_valid = 1; c0_ld_addr = 8'h50;
    #1;
    chk("R5", "same-cycle store forwarded", c0_ld_data, 16'h0009);
    chk("R5", "same-cycle hit", c0_ld_hit, 1);
    @(negedge clk);
    c0_st_valid = 0; c0_ld_valid = 0;
    drain(0, 8'h50, 16'h0008);
    drain(0, 8'h50, 16'h0009);
  endtask

  task automatic t_full;
    for (int i = 0; i < DEPTH; i++) store(0, AW'(8'h60 + i), DW'(16'h0100 + i));
    @(negedge clk);
    chk("R2", "sq_full", c0_full, 1);
    chk("R2", "st_ready when full", c0_st_ready, 0);
    c0_st_valid = 1; c0_st_addr = 8'h64; c0_st_data = 16'h00AA;
    @(negedge clk);
    chk("R2", "still stalled", c0_st_ready, 0);
    @(negedge clk);
    c0_st_valid = 0;
    for (int i = 0; i < DEPTH; i++) drain(0, AW'(8'h60 + i), DW'(16'h0100 + i));
    @(negedge clk);
    chk("R2", "empty after DEPTH drains", c0_empty, 1);
    load(0, 8'h64, "R2", 16'h0000, 0);
  endtask

  task automatic t_nogrant;
    store(1, 8'h70, 16'h0033);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      chk("R8", "drain_req while pending", c1_req, 1);
      chk("R7", "no write without grant", c1_wen, 0);
    end
    chk("R7", "memory still old", mem[8'h70], 16'h0000);
    drain(1, 8'h70, 16'h0033);
    chk("R12", "memory after drain", mem[8'h70], 16'h0033);
    load(0, 8'h70, "R6", 16'h0033, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    t_reset;
    t_race;
    t_youngest;
    t_bypass;
    t_full;
    t_nogrant;
    repeat (2) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule